// File: doc/BRIEF.md
# Vector Halving Adder with Selectable Rounding

This block computes the rounded signed average of two operand vectors, one element per clock. For each element it forms the exact sum of the two signed operands and halves it with an arithmetic right shift. It then adds a rounding increment. The increment depends on a 2-bit rounding mode and on the two lowest bits of the unshifted sum. The operands come from an external register file through a combinational read port indexed by the block. Each result goes back through a registered write port.

A start strobe launches a pass. The block samples the vector length, the mask enable and the rounding mode at that moment and keeps them for the whole pass. Elements below the vector length are active. When masking is enabled, an active element whose mask bit is 0 gets no write, so its destination keeps its old value. After the active elements, every destination index up to the maximum length receives a zero write. A pass with a zero vector length writes nothing at all. A one-cycle done pulse closes every pass.

Top module: `avg_vec_unit`

## Requirements
- R1: Rounding mode 0 (nearest, ties up) adds bit 0 of the full sum to the halved sum.
- R2: Rounding mode 1 (nearest, ties to even) adds 1 only when the two lowest sum bits are 11, and 0 otherwise.
- R3: Rounding mode 2 (round down) adds nothing, so the result is floor(sum/2).
- R4: Rounding mode 3 (round to odd) adds 1 only when the two lowest sum bits are 01, and 0 otherwise.
- R5: The sum is formed without wrap-around. With 8-bit elements, 127+127 gives 127, -128+-128 gives -128, and 127+-128 gives -1 before rounding.
- R6: With mask_en=1, an active element whose rd_mask is 0 produces no write. With mask_en=0, every active element is written.
- R7: Indices from the vector length up to MAXLEN-1 each receive one write of zero, in ascending order, one per cycle, right after the active elements.
- R8: With vlen=0 the pass makes no write at all, and done pulses in the cycle after the start edge.
- R9: done is high for exactly one cycle, the cycle after the write of index MAXLEN-1.
- R10: The rounding mode is sampled on the start edge. Changes to rmode during a pass do not affect its results.
- R11: Element i is read at rd_idx=i in the cycle after start+i and written (wr_idx=i) one cycle later, so its write is visible i+1 cycles after the start edge.
- R12: A start strobe that arrives while a pass is in progress is ignored.
- R13: A vlen larger than MAXLEN is treated as MAXLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a pass when idle |
| vlen | input | $clog2(MAXLEN)+1 | Vector length, sampled at start |
| mask_en | input | 1 | Enables per-element masking, sampled at start |
| rmode | input | 2 | Rounding mode: 0 ties up, 1 ties even, 2 down, 3 odd |
| rd_idx | output | $clog2(MAXLEN) | Element index on the read port |
| rd_a | input | EW | First operand at rd_idx |
| rd_b | input | EW | Second operand at rd_idx |
| rd_mask | input | 1 | Mask bit at rd_idx |
| wr_en | output | 1 | Write strobe |
| wr_idx | output | $clog2(MAXLEN) | Destination index |
| wr_data | output | EW | Result or tail zero |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The bench targets operand pairs at the signed extremes, where a design that wraps the sum would return values near zero of the wrong sign instead of 127 or -128. It also targets sums whose two low bits take each of the four patterns, including negative sums. There, a swapped or misdecoded rounding mode shows up as an off-by-one result in exactly one mode. It changes rmode and pulses start mid-pass, which a design that does not hold its sampled state would turn into changed results or a restarted pass. Masked elements, zero length and oversized length are also exercised: extra or missing writes, tail writes for an empty pass, and writes past MAXLEN all appear as cycle-level mismatches against the reference schedule.

// File: rtl/avg_pkg.sv
package avg_pkg;

    typedef enum logic [1:0] {
        RM_NEAR_UP   = 2'd0,
        RM_NEAR_EVEN = 2'd1,
        RM_DOWN      = 2'd2,
        RM_ODD       = 2'd3
    } rmode_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RUN   = 2'd1,
        PH_CLEAR = 2'd2,
        PH_FIN   = 2'd3
    } phase_e;

endpackage

// File: rtl/avg_round_sel.sv
module avg_round_sel
    import avg_pkg::*;
(
    input  rmode_e     rm,
    input  logic [1:0] low_bits,
    output logic       inc
);

    always_comb begin
        case (rm)
            RM_NEAR_UP:   inc = low_bits[0];
            RM_NEAR_EVEN: inc = (low_bits == 2'b11);
            RM_DOWN:      inc = 1'b0;
            default:      inc = (low_bits == 2'b01);
        endcase
    end

endmodule

// File: rtl/avg_half_add.sv
module avg_half_add
    import avg_pkg::*;
#(
    parameter int EW       = 8,
    parameter bit WIDE_SUM = 1'b1
) (
    input  logic [EW-1:0] opa,
    input  logic [EW-1:0] opb,
    input  rmode_e        rm,
    output logic [EW-1:0] res
);

    logic [EW-1:0] half;
    logic [1:0]    low;
    logic          inc;

    generate
        if (WIDE_SUM) begin : g_wide
            // one extra sign bit keeps the exact sum
            logic [EW:0] sum_w;
            assign sum_w = {opa[EW-1], opa} + {opb[EW-1], opb};
            assign half  = sum_w[EW:1];
            assign low   = sum_w[1:0];
        end else begin : g_narrow
            // element-width sum; rebuild the lost top bit from overflow
            logic [EW-1:0] sum_n;
            logic          ovf;
            assign sum_n = opa + opb;
            assign ovf   = (sum_n[EW-1] ^ opa[EW-1]) & (sum_n[EW-1] ^ opb[EW-1]);
            assign half  = {sum_n[EW-1] ^ ovf, sum_n[EW-1:1]};
            assign low   = sum_n[1:0];
        end
    endgenerate

    avg_round_sel u_round (
        .rm       (rm),
        .low_bits (low),
        .inc      (inc)
    );

    assign res = half + EW'(inc);

endmodule

// File: rtl/avg_vec_unit.sv
module avg_vec_unit
    import avg_pkg::*;
#(
    parameter int EW       = 8,
    parameter int MAXLEN   = 16,
    parameter bit WIDE_SUM = 1'b1,
    localparam int IDXW    = $clog2(MAXLEN),
    localparam int LENW    = IDXW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [LENW-1:0] vlen,
    input  logic            mask_en,
    input  logic [1:0]      rmode,
    output logic [IDXW-1:0] rd_idx,
    input  logic [EW-1:0]   rd_a,
    input  logic [EW-1:0]   rd_b,
    input  logic            rd_mask,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_idx,
    output logic [EW-1:0]   wr_data,
    output logic            done
);

    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(MAXLEN - 1);
    localparam logic [LENW-1:0] MAX_LEN  = LENW'(MAXLEN);

    typedef struct packed {
        phase_e          phase;
        logic [IDXW-1:0] idx;
        logic [LENW-1:0] len;
        logic            men;
        rmode_e          rm;
        logic            wr_en;
        logic [IDXW-1:0] wr_idx;
        logic [EW-1:0]   wr_data;
        logic            done;
    } st_t;

    st_t st_d, st_q;

    logic [EW-1:0]   avg_res;
    logic [LENW-1:0] len_in;
    logic            at_last_active;
    logic            at_top;

    avg_half_add #(
        .EW       (EW),
        .WIDE_SUM (WIDE_SUM)
    ) u_half_add (
        .opa (rd_a),
        .opb (rd_b),
        .rm  (st_q.rm),
        .res (avg_res)
    );

    assign len_in         = (vlen > MAX_LEN) ? MAX_LEN : vlen;
    assign at_last_active = ({1'b0, st_q.idx} == (st_q.len - LENW'(1)));
    assign at_top         = (st_q.idx == LAST_IDX);

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.done  = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.len   = len_in;
                    st_d.men   = mask_en;
                    st_d.rm    = rmode_e'(rmode);
                    st_d.idx   = '0;
                    st_d.phase = (vlen == '0) ? PH_FIN : PH_RUN;
                end
            end
            PH_RUN: begin
                st_d.wr_en   = !st_q.men || rd_mask;
                st_d.wr_idx  = st_q.idx;
                st_d.wr_data = avg_res;
                st_d.idx     = st_q.idx + IDXW'(1);
                if (at_last_active) begin
                    st_d.phase = at_top ? PH_FIN : PH_CLEAR;
                end
            end
            PH_CLEAR: begin
                st_d.wr_en   = 1'b1;
                st_d.wr_idx  = st_q.idx;
                st_d.wr_data = '0;
                st_d.idx     = st_q.idx + IDXW'(1);
                if (at_top) begin
                    st_d.phase = PH_FIN;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_idx  = st_q.idx;
    assign wr_en   = st_q.wr_en;
    assign wr_idx  = st_q.wr_idx;
    assign wr_data = st_q.wr_data;
    assign done    = st_q.done;

    AST_MASK_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN && st_q.men && !rd_mask) |=> !wr_en); // R6

    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ({1'b0, wr_idx} >= st_q.len)) |-> (wr_data == '0)); // R7

    AST_EMPTY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && start && vlen == '0) |=> !wr_en ##1 (done && !wr_en)); // R8

    AST_DONE_AFTER_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_FIN) |=> (done && !wr_en)); // R9

    AST_RM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE && $past(st_q.phase) != PH_IDLE) |-> $stable(st_q.rm)); // R10

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE && start) |=> $stable(st_q.len)); // R12

    AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.len <= MAX_LEN); // R13

endmodule

// File: tb/avg_vec_unit_bench.sv
`timescale 1ns/1ps
module avg_vec_unit_bench;

    localparam int EW     = 8;
    localparam int MAXLEN = 16;
    localparam int IDXW   = $clog2(MAXLEN);
    localparam int LENW   = IDXW + 1;
    localparam int SPAN   = MAXLEN + 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [LENW-1:0] vlen = '0;
    logic            mask_en = 1'b0;
    logic [1:0]      rmode = 2'd0;
    logic [IDXW-1:0] rd_idx;
    logic [EW-1:0]   rd_a, rd_b;
    logic            rd_mask;
    logic            wr_en;
    logic [IDXW-1:0] wr_idx;
    logic [EW-1:0]   wr_data;
    logic            done;

    int mem_a [MAXLEN];
    int mem_b [MAXLEN];
    bit mask_m [MAXLEN];

    bit exp_we   [SPAN];
    int exp_idx  [SPAN];
    int exp_val  [SPAN];
    bit exp_done [SPAN];

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    assign rd_a    = mem_a[rd_idx][EW-1:0];
    assign rd_b    = mem_b[rd_idx][EW-1:0];
    assign rd_mask = mask_m[rd_idx];

    avg_vec_unit #(.EW(EW), .MAXLEN(MAXLEN)) u_avg_vec_unit (
        .clk (clk), .rst_n (rst_n), .start (start), .vlen (vlen),
        .mask_en (mask_en), .rmode (rmode), .rd_idx (rd_idx),
        .rd_a (rd_a), .rd_b (rd_b), .rd_mask (rd_mask),
        .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data), .done (done)
    );

    task automatic chk(string tag, string what, int act, int expv);
        nchk++;
        if (act != expv) begin
            nerr++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic int ref_avg(int a, int b, int rm);
        int s, h, lo, inc;
        s  = a + b;
        h  = s >>> 1;
        lo = s & 3;
        case (rm)
            0: inc = s & 1;
            1: inc = (lo == 3) ? 1 : 0;
            2: inc = 0;
            default: inc = (lo == 1) ? 1 : 0;
        endcase
        return h + inc;
    endfunction

    task automatic fill(int seed);
        for (int i = 0; i < MAXLEN; i++) begin
            mem_a[i]  = ((i * 37 + seed * 11) % 256) - 128;
            mem_b[i]  = ((i * 91 + seed * 23 + 5) % 256) - 128;
            mask_m[i] = ((i + seed) % 3) != 0;
        end
        // corner pairs: extremes and each low-bit pattern of the sum
        mem_a[0] = 127;  mem_b[0] = 127;
        mem_a[1] = -128; mem_b[1] = -128;
        mem_a[2] = 127;  mem_b[2] = -128;
        mem_a[3] = -1;   mem_b[3] = -2;
        mem_a[4] = 1;    mem_b[4] = 0;
        mem_a[5] = 3;    mem_b[5] = 0;
    endtask

    task automatic build(int len_eff, bit men, int rm);
        for (int j = 0; j < SPAN; j++) begin
            exp_we[j] = 0; exp_idx[j] = 0; exp_val[j] = 0; exp_done[j] = 0;
        end
        if (len_eff == 0) begin
            exp_done[1] = 1;
        end else begin
            for (int i = 0; i < MAXLEN; i++) begin
                if (i < len_eff) begin
                    exp_we[i+1]  = !men || mask_m[i];
                    exp_val[i+1] = ref_avg(mem_a[i], mem_b[i], rm);
                end else begin
                    exp_we[i+1]  = 1;
                    exp_val[i+1] = 0;
                end
                exp_idx[i+1] = i;
            end
            exp_done[MAXLEN+1] = 1;
        end
    endtask

    task automatic run_op(int vl, bit men, int rm, int rm_late, bit poke, string tag);
        int len_eff;
        len_eff = (vl > MAXLEN) ? MAXLEN : vl;
        build(len_eff, men, rm);
        @(negedge clk);
        vlen = LENW'(vl); mask_en = men; rmode = 2'(rm); start = 1'b1;
        @(negedge clk);
        start = 1'b0; rmode = 2'(rm_late);
        for (int j = 1; j < SPAN; j++) begin
            if (poke && j == 2) begin
                start = 1'b1; vlen = '0;   // R12 mid-pass strobe
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            chk(tag, $sformatf("wr_en cycle %0d", j), int'(wr_en), int'(exp_we[j]));
            if (exp_we[j] && wr_en) begin
                chk(tag, $sformatf("wr_idx cycle %0d", j), int'(wr_idx), exp_idx[j]);
                chk(tag, $sformatf("wr_data idx %0d", exp_idx[j]),
                    int'($signed(wr_data)), exp_val[j]);
            end
            chk(tag, $sformatf("done cycle %0d", j), int'(done), int'(exp_done[j]));
        end
    endtask

    initial begin
        #4000000;
        nerr++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        fill(1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset", "wr_en", int'(wr_en), 0);
        chk("R9 reset", "done", int'(done), 0);

        // R1 R2 R3 R4 R5 R7 R9 R11: full length, each rounding mode
        run_op(MAXLEN, 1'b0, 0, 0, 1'b0, "R1 R5 R11");
        run_op(MAXLEN, 1'b0, 1, 1, 1'b0, "R2 R5 R11");
        run_op(MAXLEN, 1'b0, 2, 2, 1'b0, "R3 R5 R11");
        run_op(MAXLEN, 1'b0, 3, 3, 1'b0, "R4 R5 R9");

        // R6 R7: masked short vector with tail clearing
        fill(2);
        run_op(5, 1'b1, 1, 1, 1'b0, "R6 R7 R2");
        run_op(11, 1'b1, 3, 3, 1'b0, "R6 R7 R4");
        run_op(7, 1'b0, 0, 0, 1'b0, "R6 R7 R1");

        // R8: empty pass
        run_op(0, 1'b1, 0, 0, 1'b0, "R8");

        // R13: oversized length clamps
        fill(3);
        run_op(MAXLEN + 9, 1'b0, 3, 3, 1'b0, "R13 R4");

        // R10 R12: mode change and start strobe mid-pass are ignored
        run_op(MAXLEN, 1'b0, 0, 2, 1'b1, "R10 R12 R1");
        mask_m[0] = 1'b0;
        run_op(1, 1'b1, 2, 1, 1'b1, "R10 R12 R6 R3");

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule